// File: doc/BRIEF.md
# Dual GPIO Port with Multiplexer Address Override

This block serves two 8-bit digital ports through a small register interface with single-cycle writes and combinational reads. Port A is bidirectional. Each of its bits has a direction bit that decides whether the pin drives the port A output latch or is read back as an input. Port B is input only. Every pin input passes through a two-flop synchronizer before software can see it. A read of port A returns the output latch for output bits and the synchronized pin for input bits, so read-modify-write sequences keep the driven values intact.

A control bit enables external-multiplexer mode. In this mode the three low bits of port A become outputs whatever the direction register holds. They drive a 3-bit multiplexer address, which the converter logic loads into an internal latch with a one-cycle strobe. Reads of those three bits then return the address latch. The port A output latch is not reset, so its contents survive a reset. The direction and control registers clear on reset.

Top module: `gpio_dual_port`

## Requirements
- R1: For port A bits 7:3, and for bits 2:0 when multiplexer mode is off, `pa_oe` bit n equals the direction register bit n. A 1 means output and a 0 means input. The direction register is at address 2.
- R2: After reset the direction register and control register (address 3) read 0, and `pa_oe` is all zeros.
- R3: A read of address 0 (port A) returns, for each bit outside multiplexer override, the output latch bit when the direction bit is 1 and the synchronized pin bit when it is 0.
- R4: When control bit 0 (multiplexer enable) is 1, `pa_oe[2:0]` is 3'b111 whatever the direction bits hold, and `pa_out[2:0]` carries the multiplexer address latch.
- R5: When multiplexer enable is 1, read bits 2:0 of address 0 return the multiplexer address latch, not the pin or the output latch.
- R6: A read of address 1 returns the synchronized `pb_in`. A write to address 1 changes no register and no output.
- R7: The port A output latch (written at address 0) keeps its value through reset. The multiplexer address latch resets to 0.
- R8: The multiplexer address latch loads `mux_addr_in` in the cycle `mux_load` is high and holds its value otherwise.
- R9: A change on `pa_in` or `pb_in` becomes visible on reads after exactly two rising clock edges, and not after one.
- R10: Addresses 4 to 7 read zero. Address 3 reads back the multiplexer enable in bit 0, with all other bits zero.
- R11: When multiplexer enable is 0, `pa_out` equals the port A output latch on all eight bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| pa_in | input | 8 | Port A pin levels (asynchronous) |
| pa_out | output | 8 | Port A output drive values |
| pa_oe | output | 8 | Port A output enables, 1 drives |
| pb_in | input | 8 | Port B pin levels (asynchronous) |
| mux_addr_in | input | 3 | Multiplexer address from converter logic |
| mux_load | input | 1 | One-cycle strobe that loads `mux_addr_in` |

## Verification
The bench builds the block with its default parameters: 8-bit ports, a 3-bit multiplexer field, a 3-bit address and two synchronizer stages. With the 3-bit address, four unused addresses are available to probe for zero reads. The two-stage synchronizer puts the one-edge and two-edge visibility boundary in reach of a directed check. The 3-bit override field leaves five plain bits above it, so a single random pattern mixes overridden and ordinary port A bits in both directions.

// File: rtl/gpio_dual_port_pkg.sv
package gpio_dual_port_pkg;

    // Register selector values; the bench and checker rely on these codes.
    typedef enum logic [2:0] {
        SEL_PA_DATA = 3'd0,
        SEL_PB_DATA = 3'd1,
        SEL_PA_DIR  = 3'd2,
        SEL_CTRL    = 3'd3
    } reg_sel_e;

    localparam int unsigned CTRL_MUXEN_BIT = 0;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_dual_port_pkg::*;
#(
    parameter int unsigned PORT_W = 8,
    parameter int unsigned MUX_W  = 3,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wr_data,
    input  logic [MUX_W-1:0]  mux_addr_in,
    input  logic              mux_load,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] dir_q,
    output logic              mux_en_q,
    output logic [MUX_W-1:0]  mux_addr_q
);

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic              mux_en;
        logic [MUX_W-1:0]  mux_addr;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic [PORT_W-1:0] data_d;
    logic              hit_data, hit_dir, hit_ctrl;

    always_comb begin
        hit_data = wr_en && (addr == ADDR_W'(SEL_PA_DATA));
        hit_dir  = wr_en && (addr == ADDR_W'(SEL_PA_DIR));
        hit_ctrl = wr_en && (addr == ADDR_W'(SEL_CTRL));

        cfg_d  = cfg_q;
        data_d = data_q;

        if (hit_data) begin
            data_d = wr_data;
        end
        if (hit_dir) begin
            cfg_d.dir = wr_data;
        end
        if (hit_ctrl) begin
            cfg_d.mux_en = wr_data[CTRL_MUXEN_BIT];
        end
        if (mux_load) begin
            cfg_d.mux_addr = mux_addr_in;
        end
        // Port B data address: writes intentionally have no target.
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Output latch has no reset so its contents survive reset.
    always_ff @(posedge clk) begin
        data_q <= data_d;
    end

    assign dir_q      = cfg_q.dir;
    assign mux_en_q   = cfg_q.mux_en;
    assign mux_addr_q = cfg_q.mux_addr;

endmodule

// File: rtl/gpio_port_view.sv
module gpio_port_view
    import gpio_dual_port_pkg::*;
#(
    parameter int unsigned PORT_W = 8,
    parameter int unsigned MUX_W  = 3,
    parameter int unsigned ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] data_q,
    input  logic [PORT_W-1:0] dir_q,
    input  logic              mux_en_q,
    input  logic [MUX_W-1:0]  mux_addr_q,
    input  logic [PORT_W-1:0] pa_sync,
    input  logic [PORT_W-1:0] pb_sync,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    output logic [PORT_W-1:0] rd_data
);

    logic [PORT_W-1:0] pa_view;

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        logic plain_view;
        assign plain_view = dir_q[b] ? data_q[b] : pa_sync[b];
        if (b < MUX_W) begin : g_override
            assign pa_oe[b]   = dir_q[b] | mux_en_q;
            assign pa_out[b]  = mux_en_q ? mux_addr_q[b] : data_q[b];
            assign pa_view[b] = mux_en_q ? mux_addr_q[b] : plain_view;
        end else begin : g_plain
            assign pa_oe[b]   = dir_q[b];
            assign pa_out[b]  = data_q[b];
            assign pa_view[b] = plain_view;
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_W'(SEL_PA_DATA): rd_data = pa_view;
            ADDR_W'(SEL_PB_DATA): rd_data = pb_sync;
            ADDR_W'(SEL_PA_DIR):  rd_data = dir_q;
            ADDR_W'(SEL_CTRL):    rd_data = PORT_W'(mux_en_q) << CTRL_MUXEN_BIT;
            default:              rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port #(
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned MUX_W       = 3,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    input  logic [MUX_W-1:0]  mux_addr_in,
    input  logic              mux_load
);

    localparam int unsigned PIN_W = 2 * PORT_W;

    logic [PIN_W-1:0]  pins_sync;
    logic [PORT_W-1:0] data_q, dir_q;
    logic              mux_en_q;
    logic [MUX_W-1:0]  mux_addr_q;

    gpio_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({pb_in, pa_in}),
        .sync_o (pins_sync)
    );

    gpio_port_regs #(.PORT_W(PORT_W), .MUX_W(MUX_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .mux_addr_in(mux_addr_in),
        .mux_load   (mux_load),
        .data_q     (data_q),
        .dir_q      (dir_q),
        .mux_en_q   (mux_en_q),
        .mux_addr_q (mux_addr_q)
    );

    gpio_port_view #(.PORT_W(PORT_W), .MUX_W(MUX_W), .ADDR_W(ADDR_W)) u_view (
        .addr      (addr),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .mux_en_q  (mux_en_q),
        .mux_addr_q(mux_addr_q),
        .pa_sync   (pins_sync[PORT_W-1:0]),
        .pb_sync   (pins_sync[PIN_W-1:PORT_W]),
        .pa_out    (pa_out),
        .pa_oe     (pa_oe),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/gpio_dual_port_chk.sv
module gpio_dual_port_chk #(
    parameter int unsigned PORT_W = 8,
    parameter int unsigned MUX_W  = 3,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [PORT_W-1:0] wr_data,
    input logic [PORT_W-1:0] rd_data,
    input logic [PORT_W-1:0] pa_out,
    input logic [PORT_W-1:0] pa_oe,
    input logic [MUX_W-1:0]  mux_addr_in,
    input logic              mux_load
);

    logic ctrl_wr, dir_wr, mode_q;

    assign ctrl_wr = wr_en && (addr == ADDR_W'(3));
    assign dir_wr  = wr_en && (addr == ADDR_W'(2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (ctrl_wr) begin
            mode_q <= wr_data[0];
        end
    end

    p_oe_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pa_oe == '0));

    p_dir_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (pa_oe[PORT_W-1:MUX_W] == $past(wr_data[PORT_W-1:MUX_W])));

    p_mux_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (&pa_oe[MUX_W-1:0]));

    p_mux_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_load && mode_q && !ctrl_wr) |=> (pa_out[MUX_W-1:0] == $past(mux_addr_in)));

    p_mux_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && $past(mode_q) && !$past(mux_load)) |->
            (pa_out[MUX_W-1:0] == $past(pa_out[MUX_W-1:0])));

    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > ADDR_W'(3)) |-> (rd_data == '0));

endmodule

bind gpio_dual_port gpio_dual_port_chk #(
    .PORT_W(PORT_W), .MUX_W(MUX_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .pa_out     (pa_out),
    .pa_oe      (pa_oe),
    .mux_addr_in(mux_addr_in),
    .mux_load   (mux_load)
);

// File: tb/sim_gpio_dual_port.sv
`timescale 1ns/1ps
module sim_gpio_dual_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, pa_out, pa_oe;
    logic [7:0] pa_in = '0;
    logic [7:0] pb_in = '0;
    logic [2:0] mux_addr_in = '0;
    logic       mux_load = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] data_m = '0, dir_m = '0;
    logic       muxen_m = 1'b0;
    logic [2:0] mux_m = '0;

    always #2 clk = ~clk;

    gpio_dual_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .mux_addr_in(mux_addr_in), .mux_load(mux_load)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_pa_read();
        logic [7:0] v;
        for (int b = 0; b < 8; b++) begin
            if (muxen_m && b < 3) v[b] = mux_m[b];
            else if (dir_m[b])    v[b] = data_m[b];
            else                  v[b] = pa_in[b];
        end
        return v;
    endfunction

    function automatic logic [7:0] exp_read(input int a);
        case (a)
            0: return exp_pa_read();
            1: return pb_in;
            2: return dir_m;
            3: return {7'd0, muxen_m};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_out();
        return muxen_m ? {data_m[7:3], mux_m} : data_m;
    endfunction

    function automatic logic [7:0] exp_oe();
        return dir_m | (muxen_m ? 8'h07 : 8'h00);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            3'd0: data_m = d;
            3'd2: dir_m = d;
            3'd3: muxen_m = d[0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic set_pins(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        pa_in = a; pb_in = b;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load_mux(input logic [2:0] v);
        @(negedge clk);
        mux_addr_in = v; mux_load = 1'b1;
        @(negedge clk);
        mux_load = 1'b0;
        mux_m = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        dir_m = '0; muxen_m = 1'b0; mux_m = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            if (a == 0)      check({tag, " R3 R5 port A read"}, v, exp_read(a));
            else if (a == 1) check({tag, " R6 port B read"}, v, exp_read(a));
            else if (a >= 4) check({tag, " R10 unused address"}, v, exp_read(a));
            else             check({tag, " R10 register readback"}, v, exp_read(a));
        end
        check({tag, " R1 R4 output enables"}, pa_oe, exp_oe());
        check({tag, " R4 R11 output values"}, pa_out, exp_out());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);

        // R2 reset state
        check("R2 oe after reset", pa_oe, 8'h00);
        rd(3'd2, v); check("R2 direction after reset", v, 8'h00);
        rd(3'd3, v); check("R2 control after reset", v, 8'h00);

        // R11 / R1 basic drive
        wr(3'd0, 8'hA5);
        check("R11 pa_out follows latch", pa_out, 8'hA5);
        wr(3'd2, 8'hF0);
        check("R1 oe follows direction", pa_oe, 8'hF0);

        // R7 latch survives reset, mux latch clears
        load_mux(3'd6);
        do_reset();
        check("R7 output latch kept", pa_out, 8'hA5);
        wr(3'd2, 8'hFF);
        rd(3'd0, v); check("R7 latch read back", v, 8'hA5);
        wr(3'd3, 8'h01);
        check("R7 mux latch cleared by reset", {5'd0, pa_out[2:0]}, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd2, 8'h00);

        // R9 synchronizer depth
        set_pins(8'h00, 8'h00);
        @(negedge clk);
        pa_in = 8'h3C; pb_in = 8'hC3;
        rd(3'd0, v); check("R9 pin A not visible after one edge", v, 8'h00);
        rd(3'd0, v); check("R9 pin A visible after two edges", v, 8'h3C);
        rd(3'd1, v); check("R9 pin B visible", v, 8'hC3);

        // R6 port B write ignored
        set_pins(8'h55, 8'h12);
        wr(3'd1, 8'hFF);
        check_all("R6 after port B write");

        // R4 R5 R8 mux override, with direction bits low
        wr(3'd2, 8'h08);
        wr(3'd3, 8'hFF);
        rd(3'd3, v); check("R10 control readback only bit0", v, 8'h01);
        load_mux(3'd5);
        check("R4 low oe forced", pa_oe, 8'h0F);
        check("R4 low out carries mux", pa_out, {data_m[7:3], 3'd5});
        rd(3'd0, v); check("R5 read mux bits", v, exp_pa_read());
        @(negedge clk);
        mux_addr_in = 3'd2;
        repeat (3) @(negedge clk);
        check("R8 mux holds without strobe", {5'd0, pa_out[2:0]}, 8'h05);
        load_mux(3'd2);
        check("R8 mux loads on strobe", {5'd0, pa_out[2:0]}, 8'h02);
        wr(3'd3, 8'h00);
        check("R11 out returns to latch", pa_out, data_m);
        check("R1 oe returns to direction", pa_oe, 8'h08);

        // random phase
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: wr(3'($urandom_range(0, 7)), 8'($urandom));
                1: set_pins(8'($urandom), 8'($urandom));
                2: load_mux(3'($urandom));
                3: wr(3'd3, {7'($urandom), 1'($urandom)});
                default: wr(3'd2, 8'($urandom));
            endcase
            if (it % 5 == 4) check_all("random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule